// File: doc/BRIEF.md
# Two-Source Interrupt Level and Vector Unit

This block merges the interrupt requests of two serial peripherals, a synchronous (clocked) serial port and an asynchronous (start/stop) serial port, onto a seven-line, active-low, prioritized request bus. Each source has its own 3-bit level. A single shared vector register supplies the upper seven bits of the vector number. The lowest bit is inserted by hardware to tell the interrupt handler which port asked.

When the processor starts an acknowledge cycle, it presents the level being serviced. The block checks that level against its pending requests. On a match, and with a non-zero arbitration ID, it contends for the bus by shifting its ID out most significant bit first onto a wired-OR line. If it is still in contention after the last bit, it returns the vector with a one-cycle valid strobe. Every register write is accepted only in supervisor mode.

Top module: `dsirq_unit`

## Requirements
- R1: A source with a pending request and level N (1..7) drives `irq_n_o[N]` low. At most one line of `irq_n_o` is ever low, and all other lines stay high.
- R2: A level of 0 disables its source completely: that source drives no request line and receives no acknowledge response.
- R3: When both sources are pending at different non-zero levels, only the line of the higher level is driven low.
- R4: When both sources are pending at the same non-zero level and that level is acknowledged, the reply identifies the synchronous port (vector bit 0 = 1).
- R5: An acknowledge is answered only for a pending, enabled source whose level equals `iack_level_i`. With no match, `vec_valid_o` stays low.
- R6: Contention starts on the cycle after `iack_i` is sampled. The 4-bit ID goes out on `arb_drive_o`, most significant bit first, one bit per cycle. The block leaves contention at the first bit where it drives 0 and `arb_line_i` reads 1. An ID of 0 never contends.
- R7: A block still contending after all four bits raises `vec_valid_o` for exactly one cycle. This happens in the fifth cycle after the edge that sampled `iack_i`. `vec_o` then equals {vector register bits [7:1], 1 for a synchronous-port source or 0 for an asynchronous-port source}.
- R8: After reset, the vector register reads 0x0F, the level register and the ID register read 0, all `irq_n_o` lines are high and `vec_valid_o` is low.
- R9: Writes to vector bit 0 are ignored, and reading the vector register always returns bit 0 as 1.
- R10: Register writes take effect only when `supervisor_i` is high. Writes with `supervisor_i` low leave every register unchanged.
- R11: Serving a request does not clear it. The request line stays low until the peripheral drops its request.
- R12: Register map, selected by `reg_sel_i`: 0 = level register (bits [2:0] synchronous-port level, bits [6:4] asynchronous-port level, other bits read 0); 1 = vector register; 2 = arbitration ID in bits [3:0]; 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sync_req_i | input | 1 | Pending request from the synchronous serial port |
| async_req_i | input | 1 | Pending request from the asynchronous serial port |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Register select |
| reg_wdata_i | input | 8 | Register write data |
| supervisor_i | input | 1 | High while the processor is in supervisor mode |
| reg_rdata_o | output | 8 | Read data of the selected register |
| irq_n_o | output | 7 | Active-low request bus, lines 7..1 |
| iack_i | input | 1 | One-cycle start of an acknowledge cycle |
| iack_level_i | input | 3 | Level being acknowledged |
| arb_line_i | input | 1 | Wired-OR contention line as seen on the bus |
| arb_drive_o | output | 1 | This block's contribution to the contention line |
| vec_o | output | 8 | Vector number, valid with the strobe |
| vec_valid_o | output | 1 | One-cycle vector valid strobe |

## Verification
The bench targets the equal-level tie. A design that favours the wrong port there would return vector bit 0 as 0. It checks contention against an opponent with a higher ID, which a block that never drops out would wrongly answer. It also checks opponents with lower IDs, which a block that drops on any mismatch would fail to beat. User-mode writes and writes to vector bit 0 are checked at the read port, so a design that ignores the mode input or stores bit 0 would read back the new value. Level 0, an ID of 0 and a mismatched acknowledge level must all leave the strobe low. Requests must also stay asserted after service.

// File: rtl/dsirq_pkg.sv
package dsirq_pkg;
  localparam int LVL_W  = 3;
  localparam int VEC_W  = 8;
  localparam int DATA_W = 8;

  typedef enum logic [1:0] {
    SEL_LEVEL  = 2'd0,
    SEL_VECTOR = 2'd1,
    SEL_ARBID  = 2'd2,
    SEL_NONE   = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_CONTEND = 2'd1,
    ST_REPLY   = 2'd2
  } ack_state_e;

  // effective level of the two sources: pending and enabled, highest wins
  function automatic logic [LVL_W-1:0] top_level(
    input logic a_pend, input logic [LVL_W-1:0] a_lvl,
    input logic b_pend, input logic [LVL_W-1:0] b_lvl);
    logic [LVL_W-1:0] ea, eb;
    ea = a_pend ? a_lvl : '0;
    eb = b_pend ? b_lvl : '0;
    return (ea >= eb) ? ea : eb;
  endfunction

  // vector number: shared upper bits plus hardware source bit
  function automatic logic [VEC_W-1:0] form_vector(
    input logic [VEC_W-1:1] hi, input logic is_sync);
    return {hi, is_sync};
  endfunction
endpackage

// File: rtl/dsirq_regs.sv
module dsirq_regs
  import dsirq_pkg::*;
#(
  parameter int ID_W = 4,
  parameter logic [VEC_W-1:0] VEC_RESET = 8'h0F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        sel,
  input  logic [DATA_W-1:0] wdata,
  input  logic              supervisor,
  output logic [DATA_W-1:0] rdata,
  output logic [LVL_W-1:0]  sync_lvl,
  output logic [LVL_W-1:0]  async_lvl,
  output logic [VEC_W-1:1]  vec_hi,
  output logic [ID_W-1:0]   arb_id
);
  logic [LVL_W-1:0] sync_q, async_q;
  logic [VEC_W-1:1] vec_hi_q;
  logic [ID_W-1:0]  id_q;
  logic             wr_accept;
  logic             seen_q;

  assign wr_accept = wr_en & supervisor;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q   <= '0;
      async_q  <= '0;
      vec_hi_q <= VEC_RESET[VEC_W-1:1];
      id_q     <= '0;
      seen_q   <= 1'b0;
    end else begin
      seen_q <= 1'b1;
      if (wr_accept) begin
        unique case (reg_sel_e'(sel))
          SEL_LEVEL: begin
            sync_q  <= wdata[LVL_W-1:0];
            async_q <= wdata[LVL_W+3:4];
          end
          SEL_VECTOR: vec_hi_q <= wdata[VEC_W-1:1];
          SEL_ARBID:  id_q     <= wdata[ID_W-1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rdata = '0;
    unique case (reg_sel_e'(sel))
      SEL_LEVEL: begin
        rdata[LVL_W-1:0]   = sync_q;
        rdata[LVL_W+3:4]   = async_q;
      end
      SEL_VECTOR: rdata = form_vector(vec_hi_q, 1'b1);
      SEL_ARBID:  rdata[ID_W-1:0] = id_q;
      default: ;
    endcase
  end

  assign sync_lvl  = sync_q;
  assign async_lvl = async_q;
  assign vec_hi    = vec_hi_q;
  assign arb_id    = id_q;

  assert_user_write_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && $past(wr_en && !supervisor)) |->
      ($stable(sync_q) && $stable(async_q) && $stable(vec_hi_q) && $stable(id_q)));
endmodule

// File: rtl/dsirq_level_enc.sv
module dsirq_level_enc
  import dsirq_pkg::*;
#(
  parameter int NUM_LVL = (1 << LVL_W) - 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sync_req,
  input  logic               async_req,
  input  logic [LVL_W-1:0]   sync_lvl,
  input  logic [LVL_W-1:0]   async_lvl,
  output logic [NUM_LVL:1]   irq_n
);
  logic [LVL_W-1:0] active_lvl;
  assign active_lvl = top_level(sync_req, sync_lvl, async_req, async_lvl);

  for (genvar n = 1; n <= NUM_LVL; n++) begin : g_line
    assign irq_n[n] = (active_lvl != LVL_W'(n));
  end

  logic sync_on, async_on;
  assign sync_on  = sync_req  && (sync_lvl  != '0);
  assign async_on = async_req && (async_lvl != '0);

  assert_single_line_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~irq_n));
  assert_disabled_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_on && !async_on) |-> (&irq_n));
  assert_higher_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_on && async_on && sync_lvl > async_lvl) |->
      (~irq_n == (NUM_LVL'(1) << (sync_lvl - 1'b1))));
endmodule

// File: rtl/dsirq_ack_arb.sv
module dsirq_ack_arb
  import dsirq_pkg::*;
#(
  parameter int ID_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              iack,
  input  logic [LVL_W-1:0]  iack_lvl,
  input  logic              sync_req,
  input  logic              async_req,
  input  logic [LVL_W-1:0]  sync_lvl,
  input  logic [LVL_W-1:0]  async_lvl,
  input  logic [ID_W-1:0]   arb_id,
  input  logic [VEC_W-1:1]  vec_hi,
  input  logic              arb_line,
  output logic              arb_drive,
  output logic [VEC_W-1:0]  vec,
  output logic              vec_valid
);
  localparam int IDX_W = (ID_W > 1) ? $clog2(ID_W) : 1;

  ack_state_e       state_q;
  logic [IDX_W-1:0] bit_q;
  logic             src_sync_q;

  // named events for the assertions
  logic hit_sync, hit_async, start_ack, lost_bit, last_bit;
  assign hit_sync  = sync_req  && (sync_lvl  != '0) && (sync_lvl  == iack_lvl);
  assign hit_async = async_req && (async_lvl != '0) && (async_lvl == iack_lvl);
  assign start_ack = iack && (hit_sync || hit_async) && (arb_id != '0);
  assign arb_drive = (state_q == ST_CONTEND) && arb_id[bit_q];
  assign lost_bit  = (state_q == ST_CONTEND) && !arb_drive && arb_line;
  assign last_bit  = (bit_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      bit_q      <= '0;
      src_sync_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_ack) begin
          state_q    <= ST_CONTEND;
          bit_q      <= IDX_W'(ID_W - 1);
          src_sync_q <= hit_sync;   // synchronous port wins a tie
        end
        ST_CONTEND: begin
          if (lost_bit)      state_q <= ST_IDLE;
          else if (last_bit) state_q <= ST_REPLY;
          else               bit_q   <= bit_q - 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign vec_valid = (state_q == ST_REPLY);
  assign vec       = vec_valid ? form_vector(vec_hi, src_sync_q) : '0;

  assert_drop_out_R6: assert property (@(posedge clk) disable iff (!rst_n)
    lost_bit |=> (state_q == ST_IDLE));
  assert_zero_id_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && arb_id == '0) |=> (state_q != ST_CONTEND));
  assert_no_match_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && !hit_sync && !hit_async) |=> (state_q == ST_IDLE));
  assert_strobe_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |=> !vec_valid);
  assert_vector_base_R7: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> (vec[VEC_W-1:1] == vec_hi));
endmodule

// File: rtl/dsirq_unit.sv
module dsirq_unit
  import dsirq_pkg::*;
#(
  parameter int ID_W = 4,
  parameter logic [VEC_W-1:0] VEC_RESET = 8'h0F
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sync_req_i,
  input  logic        async_req_i,
  input  logic        reg_wr_i,
  input  logic [1:0]  reg_sel_i,
  input  logic [7:0]  reg_wdata_i,
  input  logic        supervisor_i,
  output logic [7:0]  reg_rdata_o,
  output logic [7:1]  irq_n_o,
  input  logic        iack_i,
  input  logic [2:0]  iack_level_i,
  input  logic        arb_line_i,
  output logic        arb_drive_o,
  output logic [7:0]  vec_o,
  output logic        vec_valid_o
);
  logic [LVL_W-1:0] sync_lvl, async_lvl;
  logic [VEC_W-1:1] vec_hi;
  logic [ID_W-1:0]  arb_id;

  dsirq_regs #(.ID_W(ID_W), .VEC_RESET(VEC_RESET)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_i), .sel(reg_sel_i),
    .wdata(reg_wdata_i), .supervisor(supervisor_i), .rdata(reg_rdata_o),
    .sync_lvl(sync_lvl), .async_lvl(async_lvl), .vec_hi(vec_hi), .arb_id(arb_id)
  );

  dsirq_level_enc u_enc (
    .clk(clk), .rst_n(rst_n), .sync_req(sync_req_i), .async_req(async_req_i),
    .sync_lvl(sync_lvl), .async_lvl(async_lvl), .irq_n(irq_n_o)
  );

  dsirq_ack_arb #(.ID_W(ID_W)) u_ack (
    .clk(clk), .rst_n(rst_n), .iack(iack_i), .iack_lvl(iack_level_i),
    .sync_req(sync_req_i), .async_req(async_req_i),
    .sync_lvl(sync_lvl), .async_lvl(async_lvl), .arb_id(arb_id), .vec_hi(vec_hi),
    .arb_line(arb_line_i), .arb_drive(arb_drive_o), .vec(vec_o), .vec_valid(vec_valid_o)
  );
endmodule

// File: tb/dsirq_unit_tb.sv
module dsirq_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sync_req = 0, async_req = 0, reg_wr = 0, supervisor = 0;
  logic [1:0] reg_sel = 0;
  logic [7:0] reg_wdata = 0, reg_rdata, vec;
  logic [7:1] irq_n;
  logic iack = 0, arb_drive, vec_valid, opp_bit = 0;
  logic [2:0] iack_level = 0;
  wire  arb_line = arb_drive | opp_bit;

  int n_checks = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dsirq_unit dut_i (
    .clk(clk), .rst_n(rst_n), .sync_req_i(sync_req), .async_req_i(async_req),
    .reg_wr_i(reg_wr), .reg_sel_i(reg_sel), .reg_wdata_i(reg_wdata),
    .supervisor_i(supervisor), .reg_rdata_o(reg_rdata), .irq_n_o(irq_n),
    .iack_i(iack), .iack_level_i(iack_level), .arb_line_i(arb_line),
    .arb_drive_o(arb_drive), .vec_o(vec), .vec_valid_o(vec_valid)
  );

  // bench model state
  logic [2:0] m_slvl = 0, m_alvl = 0;
  logic [7:0] m_vec = 8'h0F;
  logic [3:0] m_id = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:1] exp_irq(input logic sr, input logic [2:0] sl,
                                         input logic ar, input logic [2:0] al);
    int top = 0;
    logic [7:1] r = '1;
    if (sr && sl > top) top = sl;
    if (ar && al > top) top = al;
    for (int i = 1; i <= 7; i++) if (i == top) r[i] = 1'b0;
    return r;
  endfunction

  task automatic wr(input logic [1:0] sel, input logic [7:0] d, input logic sup);
    @(negedge clk);
    reg_sel = sel; reg_wdata = d; supervisor = sup; reg_wr = 1;
    @(negedge clk);
    reg_wr = 0; supervisor = 0;
    if (sup) begin
      if (sel == 0) begin m_slvl = d[2:0]; m_alvl = d[6:4]; end
      if (sel == 1) m_vec = {d[7:1], 1'b1};
      if (sel == 2) m_id = d[3:0];
    end
  endtask

  task automatic rd_chk(input logic [1:0] sel, input logic [7:0] exp, input string tag);
    reg_sel = sel; #1;
    chk(reg_rdata === exp, tag, reg_rdata, exp);
  endtask

  task automatic irq_chk(input string tag);
    logic [7:1] e;
    #1 e = exp_irq(sync_req, m_slvl, async_req, m_alvl);
    chk(irq_n === e, tag, irq_n, e);
  endtask

  // acknowledge at level lv against an opponent with ID opp
  task automatic do_ack(input logic [2:0] lv, input logic [3:0] opp, input string tag);
    bit hs, ha, win, opp_act;
    logic [7:0] ev;
    hs = sync_req && m_slvl != 0 && m_slvl == lv;
    ha = async_req && m_alvl != 0 && m_alvl == lv;
    win = (hs || ha) && m_id != 0 && m_id > opp;
    ev = {m_vec[7:1], hs};
    opp_act = (opp != 0);
    @(negedge clk);
    iack = 1; iack_level = lv;
    @(negedge clk);
    iack = 0;
    for (int k = 3; k >= 0; k--) begin
      opp_bit = opp_act ? opp[k] : 1'b0;
      #1;
      if (opp_act && !opp_bit && arb_line) opp_act = 0;
      if (vec_valid) chk(1'b0, {tag, " early strobe"}, 1, 0);
      @(negedge clk);
    end
    opp_bit = 0;
    chk(vec_valid === win, {tag, " strobe"}, vec_valid, win);
    if (win) chk(vec === ev, {tag, " vector"}, vec, ev);
    @(negedge clk);
    chk(vec_valid === 1'b0, {tag, " pulse R7"}, vec_valid, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=1 expected=0");
    finish_run();
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R8 reset state
    rd_chk(2'd1, 8'h0F, "R8 vector reset");
    rd_chk(2'd0, 8'h00, "R8 level reset");
    rd_chk(2'd2, 8'h00, "R8 id reset");
    rd_chk(2'd3, 8'h00, "R12 unused select");
    chk(irq_n === 7'h7F && vec_valid === 1'b0, "R8 outputs", {irq_n, vec_valid}, 8'hFE);

    // R10 user-mode writes dropped
    wr(2'd1, 8'hA4, 1'b0);
    rd_chk(2'd1, 8'h0F, "R10 vector user write");
    wr(2'd0, 8'h35, 1'b0);
    rd_chk(2'd0, 8'h00, "R10 level user write");

    // R9 bit 0 of vector
    wr(2'd1, 8'hA4, 1'b1);
    rd_chk(2'd1, 8'hA5, "R9 bit0 reads 1");
    wr(2'd2, 8'h09, 1'b1);
    rd_chk(2'd2, 8'h09, "R12 id readback");

    // R2 level 0 disables
    wr(2'd0, 8'h00, 1'b1);
    sync_req = 1; async_req = 1;
    irq_chk("R2 level zero quiet");
    do_ack(3'd0, 4'd0, "R2 ack at zero");

    // R1 R3 different levels
    wr(2'd0, 8'h25, 1'b1);            // async 2, sync 5
    rd_chk(2'd0, 8'h25, "R12 level readback");
    irq_chk("R3 higher level sync");
    wr(2'd0, 8'h61, 1'b1);            // async 6, sync 1
    irq_chk("R3 higher level async");
    do_ack(3'd6, 4'd0, "R5 async match");
    do_ack(3'd3, 4'd0, "R5 level mismatch");
    do_ack(3'd1, 4'd3, "R6 beat lower id");
    do_ack(3'd1, 4'd12, "R6 lose to higher id");

    // R4 tie
    wr(2'd0, 8'h44, 1'b1);
    irq_chk("R1 tie single line");
    do_ack(3'd4, 4'd0, "R4 tie sync first");

    // R11 still pending after service
    irq_chk("R11 stays pending");
    sync_req = 0;
    irq_chk("R11 async remains");
    async_req = 0;
    irq_chk("R11 released");

    // R6 zero id
    wr(2'd2, 8'h00, 1'b1);
    sync_req = 1;
    do_ack(3'd4, 4'd0, "R6 zero id silent");

    // random mix
    for (int it = 0; it < 80; it++) begin
      logic [7:0] d;
      logic [3:0] opp;
      d = 8'($urandom);
      wr(2'd0, d & 8'h77, 1'b1);
      wr(2'd1, 8'($urandom), 1'b1);
      wr(2'd2, 8'($urandom_range(0, 15)), ($urandom_range(0, 3) != 0));
      sync_req = 1'($urandom); async_req = 1'($urandom);
      irq_chk("R1 random level");
      rd_chk(2'd1, m_vec, "R9 random vector");
      opp = 4'($urandom_range(0, 15));
      if (opp == m_id) opp = 4'd0;
      do_ack(($urandom_range(0, 1) != 0) ? m_slvl : (($urandom_range(0, 1) != 0) ? m_alvl : 3'($urandom)),
             opp, "R7 random ack");
    end
    finish_run();
  end
endmodule